// File: doc/BRIEF.md
# Serial Configuration Register Write Port

This block lets a host load a small bank of configuration registers over three shared pins: a serial clock, a serial data line and a latch line. The pins only act as a configuration port while a separate mode-select input is high. At other times they belong to a different function, and this block ignores them. While the latch line is low, the host clocks in a frame. The frame carries a register address and then a data field, most-significant bit first. The host then raises the latch line and holds it high for a fixed number of further serial clocks. On the last of those clocks, the data field replaces the contents of the addressed register.

All pins are sampled in the block's own clock domain through synchronizers, and serial clock edges are found there. Every register is presented in parallel on one flat output bus for neighbouring logic. A one-cycle, one-hot strobe names the register that has just been written. The port only writes. There is no stream interface and no back-pressure, because a commit always lands in the register bank in the cycle it is decided, and there is nothing for the host or for downstream logic to stall.

Top module: `cfg_serial_port`

## Requirements
- R1: After a synchronous reset (`rst_n` low on a clock edge), all eight 6-bit registers read zero and no write strobe is raised.
- R2: A frame is 9 bits sent MSB first: a 3-bit register address (first bit = address bit 2), then 6 data bits (data bit 5 first). A completed commit makes the addressed register equal to the data field. Register i occupies `cfg_regs_o[6*i+5 : 6*i]`.
- R3: A bit is taken from `ser_dat_i` only on a rising edge of `ser_clk_i` while `ser_lat_i` is low and `mode_i` is high. Changes of the data line with no rising serial clock edge shift nothing.
- R4: When more than 9 bits are shifted before the latch rises, only the 9 most recently shifted bits form the frame.
- R5: After the latch line rises, the commit happens on the third rising serial clock edge seen while the latch stays high, and not earlier. If the latch falls before that third edge, the write is abandoned and no register changes.
- R6: Each commit raises exactly one bit of `wr_stb_o`, for exactly one clock cycle. Bit i is set when register i is written. Further serial clock edges while the latch stays high cause no further commit.
- R7: While `mode_i` is low, the three serial pins have no effect on any register or strobe. Dropping `mode_i` also discards any partly shifted frame.
- R8: The shift register is emptied after every commit and every abandoned write. A following frame of fewer than 9 bits therefore sees zeros in its unsent leading positions.
- R9: A write changes only the addressed register. Every other register keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; all pins are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 1 | Mode select; the serial port is live only while high |
| ser_clk_i | input | 1 | Serial clock; its rising edges shift data or count commit clocks |
| ser_dat_i | input | 1 | Serial data in, MSB first |
| ser_lat_i | input | 1 | Low: shift enable; rising edge: arm commit |
| cfg_regs_o | output | 48 | All registers, register i at bits [6*i+5:6*i] |
| wr_stb_o | output | 8 | One-cycle one-hot pulse naming the register just written |

## Verification
A table of frames is walked with distinct address and data patterns, including all-ones, all-zeros and alternating bits. These show whether the address and data fields are split at the right position and in MSB-first order, and whether neighbouring registers are disturbed. Overlong frames distinguish keeping the newest bits from keeping the oldest. Short frames sent after a commit, an abandon or a drop of the mode line show whether stale bits leak into the next frame. Latches held for exactly two and then three serial clocks separate a commit on the third edge from one on an earlier edge. Extra edges afterwards show whether a second commit can follow the first.

// File: rtl/cfg_serial_pkg.sv
package cfg_serial_pkg;

  // Commit controller states.
  typedef enum logic {
    CS_IDLE  = 1'b0,
    CS_ARMED = 1'b1
  } commit_state_e;

  // Pin order inside the synchronizer vector.
  localparam int PIN_DAT  = 0;
  localparam int PIN_CLK  = 1;
  localparam int PIN_LAT  = 2;
  localparam int PIN_MODE = 3;
  localparam int PIN_CNT  = 4;

endpackage

// File: rtl/cfg_pin_sync.sv
// Multi-stage synchronizer with rising edge detection, one chain per pin.
module cfg_pin_sync #(
  parameter int N_PINS = 4,
  parameter int STAGES = 2   // at least 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] pin_i,
  output logic [N_PINS-1:0] lvl_o,
  output logic [N_PINS-1:0] rise_o
);

  for (genvar p = 0; p < N_PINS; p++) begin : g_pin
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        chain_q <= '0;
        prev_q  <= 1'b0;
      end else begin
        chain_q <= {chain_q[STAGES-2:0], pin_i[p]};
        prev_q  <= chain_q[STAGES-1];
      end
    end

    assign lvl_o[p]  = chain_q[STAGES-1];
    assign rise_o[p] = chain_q[STAGES-1] & ~prev_q;
  end

endmodule

// File: rtl/cfg_frame_shift.sv
// Frame shift register: newest bit enters at bit 0, clear has priority.
module cfg_frame_shift #(
  parameter int FRAME_W = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_i,
  input  logic               shift_i,
  input  logic               bit_i,
  output logic [FRAME_W-1:0] frame_o
);

  logic [FRAME_W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else if (clr_i) begin
      sh_q <= '0;
    end else if (shift_i) begin
      sh_q <= {sh_q[FRAME_W-2:0], bit_i};
    end
  end

  assign frame_o = sh_q;

endmodule

// File: rtl/cfg_commit_ctrl.sv
// Arms on a latch rise, counts serial clock edges while the latch holds,
// and commits on the HOLD_CLKS-th edge. Latch or mode loss abandons.
module cfg_commit_ctrl
  import cfg_serial_pkg::*;
#(
  parameter int HOLD_CLKS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_i,
  input  logic lat_i,
  input  logic lat_rise_i,
  input  logic sck_rise_i,
  output logic commit_o,
  output logic abandon_o
);

  localparam int CW = $clog2(HOLD_CLKS + 1);

  commit_state_e st_q;
  logic [CW-1:0] cnt_q;
  logic          held;
  logic          last_edge;

  always_comb begin
    held      = mode_i && lat_i;
    last_edge = (cnt_q == CW'(HOLD_CLKS - 1));
    commit_o  = (st_q == CS_ARMED) && held && sck_rise_i && last_edge;
    abandon_o = (st_q == CS_ARMED) && !held;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= CS_IDLE;
      cnt_q <= '0;
    end else begin
      case (st_q)
        CS_IDLE: begin
          cnt_q <= '0;
          if (mode_i && lat_rise_i) st_q <= CS_ARMED;
        end
        CS_ARMED: begin
          if (commit_o || abandon_o) begin
            st_q  <= CS_IDLE;
            cnt_q <= '0;
          end else if (sck_rise_i) begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        default: begin
          st_q  <= CS_IDLE;
          cnt_q <= '0;
        end
      endcase
    end
  end

endmodule

// File: rtl/cfg_reg_bank.sv
// Register storage with per-register write strobe.
module cfg_reg_bank #(
  parameter int NREG = 8,
  parameter int DW   = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we_i,
  input  logic [$clog2(NREG)-1:0] addr_i,
  input  logic [DW-1:0]           data_i,
  output logic [NREG*DW-1:0]      regs_o,
  output logic [NREG-1:0]         stb_o
);

  localparam int AW = $clog2(NREG);

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic [DW-1:0] val_q;
    logic          stb_q;
    logic          hit;

    assign hit = we_i && (addr_i == AW'(r));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        val_q <= '0;
        stb_q <= 1'b0;
      end else begin
        stb_q <= hit;
        if (hit) val_q <= data_i;
      end
    end

    assign regs_o[r*DW +: DW] = val_q;
    assign stb_o[r]           = stb_q;
  end

endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port
  import cfg_serial_pkg::*;
#(
  parameter int NREG        = 8,
  parameter int DW          = 6,
  parameter int HOLD_CLKS   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode_i,
  input  logic               ser_clk_i,
  input  logic               ser_dat_i,
  input  logic               ser_lat_i,
  output logic [NREG*DW-1:0] cfg_regs_o,
  output logic [NREG-1:0]    wr_stb_o
);

  localparam int AW = $clog2(NREG);
  localparam int FW = AW + DW;

  logic [PIN_CNT-1:0] pins_raw;
  logic [PIN_CNT-1:0] pins_lvl;
  logic [PIN_CNT-1:0] pins_rise;

  logic mode_s, lat_s, dat_s, sck_rise, lat_rise;
  logic commit, abandon, sh_clr, sh_en;
  logic [FW-1:0] shreg;

  always_comb begin
    pins_raw           = '0;
    pins_raw[PIN_DAT]  = ser_dat_i;
    pins_raw[PIN_CLK]  = ser_clk_i;
    pins_raw[PIN_LAT]  = ser_lat_i;
    pins_raw[PIN_MODE] = mode_i;
  end

  cfg_pin_sync #(
    .N_PINS (PIN_CNT),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (pins_raw),
    .lvl_o  (pins_lvl),
    .rise_o (pins_rise)
  );

  assign mode_s   = pins_lvl[PIN_MODE];
  assign lat_s    = pins_lvl[PIN_LAT];
  assign dat_s    = pins_lvl[PIN_DAT];
  assign sck_rise = pins_rise[PIN_CLK];
  assign lat_rise = pins_rise[PIN_LAT];

  assign sh_en  = mode_s && !lat_s && sck_rise;
  assign sh_clr = commit || abandon || !mode_s;

  cfg_frame_shift #(
    .FRAME_W (FW)
  ) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (sh_clr),
    .shift_i (sh_en),
    .bit_i   (dat_s),
    .frame_o (shreg)
  );

  cfg_commit_ctrl #(
    .HOLD_CLKS (HOLD_CLKS)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_i     (mode_s),
    .lat_i      (lat_s),
    .lat_rise_i (lat_rise),
    .sck_rise_i (sck_rise),
    .commit_o   (commit),
    .abandon_o  (abandon)
  );

  cfg_reg_bank #(
    .NREG (NREG),
    .DW   (DW)
  ) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .we_i   (commit),
    .addr_i (shreg[FW-1 -: AW]),
    .data_i (shreg[DW-1:0]),
    .regs_o (cfg_regs_o),
    .stb_o  (wr_stb_o)
  );

endmodule

// File: rtl/cfg_serial_port_chk.sv
module cfg_serial_port_chk #(
  parameter int NREG = 8,
  parameter int DW   = 6,
  parameter int FW   = 9
) (
  input logic               clk,
  input logic               rst_n,
  input logic               mode_s,
  input logic               lat_s,
  input logic [FW-1:0]      shreg,
  input logic [NREG*DW-1:0] cfg_regs_o,
  input logic [NREG-1:0]    wr_stb_o
);

  AST_STB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_stb_o)); // R6

  AST_REG_CHANGE_STROBED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_regs_o != $past(cfg_regs_o)) |-> (wr_stb_o != '0)); // R9

  AST_STB_LATCH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb_o != '0) |-> $past(lat_s && mode_s)); // R5

  AST_MODE_LOW_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_s |=> (shreg == '0)); // R7

endmodule

bind cfg_serial_port cfg_serial_port_chk #(
  .NREG (NREG),
  .DW   (DW),
  .FW   (FW)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_s     (mode_s),
  .lat_s      (lat_s),
  .shreg      (shreg),
  .cfg_regs_o (cfg_regs_o),
  .wr_stb_o   (wr_stb_o)
);

// File: tb/cfg_serial_port_tb.sv
module cfg_serial_port_tb;

  localparam int NREG = 8;
  localparam int DW   = 6;
  localparam int PH   = 6;

  localparam logic [8:0] VEC [0:7] = '{
    {3'd0, 6'h15}, {3'd1, 6'h3F}, {3'd2, 6'h2A}, {3'd7, 6'h01},
    {3'd5, 6'h20}, {3'd3, 6'h0C}, {3'd6, 6'h33}, {3'd1, 6'h00}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode = 1'b0, sck = 1'b0, sdi = 1'b0, lat = 1'b0;
  logic [NREG*DW-1:0] regs;
  logic [NREG-1:0]    stb;

  int n_chk = 0, n_fail = 0;
  int stb_cnt = 0, last_idx = -1;
  logic [DW-1:0] model [NREG];

  always #10 clk = ~clk;

  cfg_serial_port u_dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .ser_clk_i(sck),
    .ser_dat_i(sdi), .ser_lat_i(lat), .cfg_regs_o(regs), .wr_stb_o(stb)
  );

  always @(negedge clk) begin
    if (rst_n && stb != '0) begin
      stb_cnt <= stb_cnt + $countones(stb);
      for (int i = 0; i < NREG; i++) if (stb[i]) last_idx <= i;
    end
  end

  task automatic tick(int n); repeat (n) @(negedge clk); endtask

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_sck(); sck = 1'b1; tick(PH); sck = 1'b0; tick(PH); endtask

  task automatic shift_bits(logic [15:0] w, int nb);
    for (int i = nb - 1; i >= 0; i--) begin
      sdi = w[i]; tick(PH); pulse_sck();
    end
  endtask

  task automatic latch(int pulses);
    lat = 1'b1; tick(PH);
    repeat (pulses) pulse_sck();
    lat = 1'b0; tick(2 * PH);
  endtask

  task automatic check_bank(string req);
    int bad = -1;
    for (int i = 0; i < NREG; i++)
      if (regs[i*DW +: DW] !== model[i]) bad = i;
    if (bad < 0) chk(1'b1, req, 0, 0);
    else chk(1'b0, req, int'(regs[bad*DW +: DW]), int'(model[bad]));
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  initial begin
    int c0;
    for (int i = 0; i < NREG; i++) model[i] = '0;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    // R1 reset state
    chk(regs == '0, "R1 regs", int'(regs[31:0]), 0);
    chk(stb == '0 && stb_cnt == 0, "R1 strobe", stb_cnt, 0);
    mode = 1'b1; tick(PH);

    // Table walk: R2 field split, R6 strobe, R9 isolation
    for (int v = 0; v < 8; v++) begin
      c0 = stb_cnt;
      sdi = 1'b1; tick(PH); sdi = 1'b0; tick(PH);   // R3: data toggles w/o clock
      shift_bits({7'd0, VEC[v]}, 9);
      latch(3);
      model[VEC[v][8:6]] = VEC[v][5:0];
      check_bank("R2 R9 frame");
      chk(stb_cnt == c0 + 1 && last_idx == int'(VEC[v][8:6]), "R6 strobe index",
          last_idx, int'(VEC[v][8:6]));
    end

    // R4: 12 bits shifted, newest 9 form the frame
    shift_bits(16'b0000_111_011_000101, 12);
    latch(3);
    model[3] = 6'h05;
    check_bank("R4 overlong");

    // R5: abandon after two edges, then R8 short frame sees zeros
    c0 = stb_cnt;
    shift_bits({7'd0, 3'd2, 6'h11}, 9);
    latch(2);
    check_bank("R5 abandon");
    chk(stb_cnt == c0, "R5 abandon strobe", stb_cnt, c0);
    shift_bits(16'b10111, 5);
    latch(3);
    model[0] = 6'h17;
    check_bank("R8 clear after abandon");

    // R8 after commit: short frame again
    shift_bits(16'b01, 2);
    latch(3);
    model[0] = 6'h01;
    check_bank("R8 clear after commit");

    // R5: exact third edge; R6 no second commit
    c0 = stb_cnt;
    shift_bits({7'd0, 3'd4, 6'h2D}, 9);
    lat = 1'b1; tick(PH);
    pulse_sck(); pulse_sck(); tick(PH);
    check_bank("R5 not before third edge");
    chk(stb_cnt == c0, "R5 early strobe", stb_cnt, c0);
    pulse_sck(); tick(PH);
    model[4] = 6'h2D;
    check_bank("R5 third edge commit");
    pulse_sck(); pulse_sck(); pulse_sck();
    lat = 1'b0; tick(2 * PH);
    chk(stb_cnt == c0 + 1, "R6 single commit", stb_cnt, c0 + 1);

    // R7: mode low ignores a full frame
    c0 = stb_cnt;
    mode = 1'b0; tick(PH);
    shift_bits({7'd0, 3'd6, 6'h2A}, 9);
    latch(3);
    check_bank("R7 mode low");
    chk(stb_cnt == c0, "R7 mode low strobe", stb_cnt, c0);

    // R7: mode drop discards a partial frame
    mode = 1'b1; tick(PH);
    shift_bits(16'b1111, 4);
    mode = 1'b0; tick(PH); mode = 1'b1; tick(PH);
    shift_bits(16'b10110, 5);
    latch(3);
    model[0] = 6'h16;
    check_bank("R7 partial discarded");

    finish_run();
  end

endmodule